// File: doc/BRIEF.md
# Processor Presence Bitmap Port with Hot-Add Event and Mode Switch

This block serves a byte-addressed, read-only window in which each bit says whether the processor with that hardware ID is present. Bit position equals hardware ID: processor `i` sits in byte `i/8`, bit `i%8`. The boot processor (ID 0) is always reported present. When a hot-add request arrives for an in-range ID, the block sets that processor's bit. It also sets the hot-plug bit of a general-purpose event status vector, and that bit drives the interrupt line to the firmware.

Writes to the window never change the bitmap. One write has a side effect. A zero byte written anywhere in the first 32-bit word of the window tells the block that the guest wants the newer register interface. From then on a sticky mode output is raised, and bitmap reads return zero so that the newer register block can own the address range. Only a power-on reset clears the mode output. Processors are never removed, so a set bit stays set until reset.

Top module: `pb_legacy_port`

## Requirements
- R1: After power-on reset, only bit 0 of the bitmap is set, the event status vector is all zero, and `irq_out` and `modern_mode` are low.
- R2: A read access (`acc_en`=1, `acc_wr`=0) at byte offset k returns presence bits 8k+7..8k on `rd_data` in the cycle after the access. Bit i is 1 when processor i is present. Offsets past the end of the bitmap but inside the window read 0x00. In any cycle that follows no read access, `rd_data` is 0x00.
- R3: Bit 0 (the boot processor) always reads as 1 while legacy reads are served.
- R4: A hot-add (`add_valid`=1) with `add_id` < NUM_CPU sets bit `add_id` from the next cycle onward. A hot-add with `add_id` >= NUM_CPU changes no bit and raises no event.
- R5: Writes to any offset never change the bitmap, and no event ever clears a set bit.
- R6: An in-range hot-add sets event status bit GPE_BIT (default 2) of `gpe_sts` in the next cycle. All other status bits stay 0.
- R7: A 1 in `gpe_clr` at bit GPE_BIT clears that status bit in the next cycle. A hot-add in the same cycle takes priority and leaves the bit set.
- R8: `irq_out` is high exactly when some status bit and its matching `gpe_en` bit are both 1. The output is combinational from the status register.
- R9: A write of data 0x00 to byte offset 0, 1, 2 or 3 raises `modern_mode` in the next cycle. A write of nonzero data, or a write to offset 4 or above, does not.
- R10: `modern_mode` stays high until power-on reset. While it is high, every read returns 0x00. Hot-adds still update the bitmap and the event status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| acc_en | input | 1 | Byte access strobe |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_addr | input | ADDR_W | Byte offset in the window |
| acc_wdata | input | 8 | Write data |
| rd_data | output | 8 | Read data, one cycle after the access |
| add_valid | input | 1 | Hot-add request |
| add_id | input | ID_W | Hardware ID of the added processor |
| gpe_clr | input | GPE_W | Write-one-to-clear mask for the event status |
| gpe_en | input | GPE_W | Event enable mask |
| gpe_sts | output | GPE_W | Event status vector |
| irq_out | output | 1 | System control interrupt |
| modern_mode | output | 1 | Sticky request to switch to the newer interface |

## Verification
The assertions assume that a read and a write are never presented in the same cycle, because the access port carries one direction bit per strobe. They also assume that `rst_n` is applied at power-on before any access. The event-clear property is written only for cycles without an in-range hot-add, so it takes the priority rule as given. The stimulus drives one access per cycle with every input changed on the falling edge. It mixes out-of-range IDs, simultaneous add and clear, and zero and nonzero writes at offsets inside and outside the first word, and it repeats a reset to show that the mode flag clears.

// File: rtl/pb_pkg.sv
package pb_pkg;
   localparam int BYTE_W = 8;
   localparam int SWITCH_WORD_BYTES = 4;
   typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/pb_presence.sv
module pb_presence
   import pb_pkg::*;
#(
   parameter int NUM_CPU   = 20,
   parameter int ID_W      = 8,
   parameter int WIN_BYTES = 32,
   parameter int ADDR_W    = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              set_en,
   input  logic [ID_W-1:0]   set_id,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] rd_addr,
   input  logic              block_rd,
   output byte_t             rd_data
);
   localparam int PAD_W = WIN_BYTES * BYTE_W;

   logic [NUM_CPU-1:0] present_q;
   logic [PAD_W-1:0]   window;
   byte_t              sel_byte;
   byte_t              rd_q;

   for (genvar i = 0; i < NUM_CPU; i++) begin : g_bit
      if (i == 0) begin : g_boot
         assign present_q[i] = 1'b1;
      end else begin : g_slot
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               present_q[i] <= 1'b0;
            else if (set_en && set_id == ID_W'(i))
               present_q[i] <= 1'b1;
         end
      end
   end

   assign window   = PAD_W'(present_q);
   assign sel_byte = window[{rd_addr, 3'b000} +: BYTE_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rd_q <= '0;
      else
         rd_q <= (rd_en && !block_rd) ? sel_byte : '0;
   end

   assign rd_data = rd_q;
endmodule

// File: rtl/pb_gpe.sv
module pb_gpe #(
   parameter int GPE_W   = 8,
   parameter int GPE_BIT = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             raise,
   input  logic [GPE_W-1:0] clr,
   input  logic [GPE_W-1:0] en,
   output logic [GPE_W-1:0] sts,
   output logic             irq
);
   for (genvar b = 0; b < GPE_W; b++) begin : g_sts
      if (b == GPE_BIT) begin : g_hp
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               sts[b] <= 1'b0;
            else if (raise)
               sts[b] <= 1'b1;
            else if (clr[b])
               sts[b] <= 1'b0;
         end
      end else begin : g_unused
         assign sts[b] = 1'b0;
      end
   end

   assign irq = |(sts & en);
endmodule

// File: rtl/pb_modesw.sv
module pb_modesw
   import pb_pkg::*;
#(
   parameter int ADDR_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  byte_t             wdata,
   output logic              modern
);
   logic hit;
   logic modern_q;

   assign hit = wr_en && (wdata == '0) &&
                (32'(addr) < SWITCH_WORD_BYTES);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         modern_q <= 1'b0;
      else if (hit)
         modern_q <= 1'b1;
   end

   assign modern = modern_q;
endmodule

// File: rtl/pb_legacy_port.sv
module pb_legacy_port
   import pb_pkg::*;
#(
   parameter int NUM_CPU   = 20,
   parameter int ID_W      = 8,
   parameter int WIN_BYTES = 32,
   parameter int GPE_W     = 8,
   parameter int GPE_BIT   = 2,
   localparam int ADDR_W   = $clog2(WIN_BYTES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_en,
   input  logic              acc_wr,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic [7:0]        acc_wdata,
   output logic [7:0]        rd_data,
   input  logic              add_valid,
   input  logic [ID_W-1:0]   add_id,
   input  logic [GPE_W-1:0]  gpe_clr,
   input  logic [GPE_W-1:0]  gpe_en,
   output logic [GPE_W-1:0]  gpe_sts,
   output logic              irq_out,
   output logic              modern_mode
);
   localparam int MAP_BYTES = (NUM_CPU + BYTE_W - 1) / BYTE_W;

   if (NUM_CPU < 1) begin : g_err_cpu
      $error("NUM_CPU must be at least 1");
   end
   if (WIN_BYTES < MAP_BYTES || WIN_BYTES < SWITCH_WORD_BYTES) begin : g_err_win
      $error("WIN_BYTES too small for bitmap or switch word");
   end
   if ((2 ** ID_W) < NUM_CPU) begin : g_err_id
      $error("ID_W cannot address every processor");
   end
   if (GPE_BIT >= GPE_W) begin : g_err_gpe
      $error("GPE_BIT outside event vector");
   end

   logic add_ok;
   logic rd_req;
   logic wr_req;

   assign add_ok = add_valid && (32'(add_id) < NUM_CPU);
   assign rd_req = acc_en && !acc_wr;
   assign wr_req = acc_en && acc_wr;

   pb_presence #(
      .NUM_CPU(NUM_CPU), .ID_W(ID_W), .WIN_BYTES(WIN_BYTES), .ADDR_W(ADDR_W)
   ) u_map (
      .clk(clk), .rst_n(rst_n), .set_en(add_ok), .set_id(add_id),
      .rd_en(rd_req), .rd_addr(acc_addr), .block_rd(modern_mode),
      .rd_data(rd_data)
   );

   pb_gpe #(.GPE_W(GPE_W), .GPE_BIT(GPE_BIT)) u_gpe (
      .clk(clk), .rst_n(rst_n), .raise(add_ok), .clr(gpe_clr),
      .en(gpe_en), .sts(gpe_sts), .irq(irq_out)
   );

   pb_modesw #(.ADDR_W(ADDR_W)) u_mode (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_req), .addr(acc_addr),
      .wdata(acc_wdata), .modern(modern_mode)
   );
endmodule

// File: rtl/pb_legacy_port_chk.sv
module pb_legacy_port_chk #(
   parameter int NUM_CPU = 20,
   parameter int ID_W    = 8,
   parameter int ADDR_W  = 5,
   parameter int GPE_W   = 8,
   parameter int GPE_BIT = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              acc_en,
   input logic              acc_wr,
   input logic [ADDR_W-1:0] acc_addr,
   input logic [7:0]        acc_wdata,
   input logic [7:0]        rd_data,
   input logic              add_valid,
   input logic [ID_W-1:0]   add_id,
   input logic [GPE_W-1:0]  gpe_clr,
   input logic [GPE_W-1:0]  gpe_sts,
   input logic              modern_mode
);
   logic add_in;
   assign add_in = add_valid && (32'(add_id) < NUM_CPU);

   // R3
   boot_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_en && !acc_wr && acc_addr == '0 && !modern_mode) |=> rd_data[0]);

   // R2
   idle_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(acc_en && !acc_wr) |=> rd_data == 8'h00);

   // R6
   evt_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      add_in |=> gpe_sts[GPE_BIT]);

   // R7
   evt_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (gpe_clr[GPE_BIT] && !add_in) |=> !gpe_sts[GPE_BIT]);

   // R9
   mode_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_en && acc_wr && acc_wdata == 8'h00 && 32'(acc_addr) < 4) |=> modern_mode);

   // R10
   mode_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      modern_mode |=> modern_mode);

   // R10
   mode_rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (modern_mode && acc_en && !acc_wr) |=> rd_data == 8'h00);
endmodule

bind pb_legacy_port pb_legacy_port_chk #(
   .NUM_CPU(NUM_CPU), .ID_W(ID_W), .ADDR_W(ADDR_W),
   .GPE_W(GPE_W), .GPE_BIT(GPE_BIT)
) u_chk (
   .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wr(acc_wr),
   .acc_addr(acc_addr), .acc_wdata(acc_wdata), .rd_data(rd_data),
   .add_valid(add_valid), .add_id(add_id), .gpe_clr(gpe_clr),
   .gpe_sts(gpe_sts), .modern_mode(modern_mode)
);

// File: tb/sim_pb_legacy_port.sv
module sim_pb_legacy_port;
   localparam int N    = 20;
   localparam int IDW  = 8;
   localparam int WIN  = 32;
   localparam int AW   = 5;
   localparam int GW   = 8;
   localparam int GB   = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          acc_en = 1'b0, acc_wr = 1'b0;
   logic [AW-1:0] acc_addr = '0;
   logic [7:0]    acc_wdata = '0;
   logic [7:0]    rd_data;
   logic          add_valid = 1'b0;
   logic [IDW-1:0] add_id = '0;
   logic [GW-1:0] gpe_clr = '0, gpe_en = '0;
   logic [GW-1:0] gpe_sts;
   logic          irq_out, modern_mode;

   always #5 clk = ~clk;

   pb_legacy_port u0 (
      .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wr(acc_wr),
      .acc_addr(acc_addr), .acc_wdata(acc_wdata), .rd_data(rd_data),
      .add_valid(add_valid), .add_id(add_id), .gpe_clr(gpe_clr),
      .gpe_en(gpe_en), .gpe_sts(gpe_sts), .irq_out(irq_out),
      .modern_mode(modern_mode)
   );

   // behavioural reference
   bit        m_pres [N];
   bit        m_sts;
   bit        m_mode;
   logic [7:0] m_rd;
   int n_chk = 0, n_bad = 0;
   bit done = 0;

   function automatic logic [7:0] m_byte(int a);
      logic [7:0] v = '0;
      for (int b = 0; b < 8; b++) if (a * 8 + b < N) v[b] = m_pres[a * 8 + b];
      return v;
   endfunction

   task automatic m_reset();
      for (int i = 0; i < N; i++) m_pres[i] = (i == 0);
      m_sts = 0; m_mode = 0; m_rd = '0;
   endtask

   task automatic cmp(string tag, logic [63:0] act, logic [63:0] exp, string what);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   task automatic compare(string tag);
      logic [GW-1:0] es;
      es = '0; es[GB] = m_sts;
      cmp(tag, 64'(rd_data), 64'(m_rd), "rd_data");
      cmp(tag, 64'(gpe_sts), 64'(es), "gpe_sts");
      cmp(tag, 64'(irq_out), 64'(m_sts & gpe_en[GB]), "irq_out");
      cmp(tag, 64'(modern_mode), 64'(m_mode), "modern_mode");
   endtask

   // one cycle: check outputs, drive inputs, advance model
   task automatic step(string tag, bit en, bit wr, int addr, logic [7:0] wd,
                       bit av, int aid, bit clr);
      @(negedge clk);
      compare(tag);
      acc_en = en; acc_wr = wr; acc_addr = AW'(addr); acc_wdata = wd;
      add_valid = av; add_id = IDW'(aid);
      gpe_clr = '0; gpe_clr[GB] = clr;
      m_rd = (en && !wr && !m_mode) ? m_byte(addr) : 8'h00;
      if (av && aid < N) begin m_pres[aid] = 1; m_sts = 1; end
      else if (clr) m_sts = 0;
      if (en && wr && wd == 8'h00 && addr < 4) m_mode = 1;
   endtask

   task automatic idle(string tag);
      step(tag, 0, 0, 0, 8'h00, 0, 0, 0);
   endtask
   task automatic rd(string tag, int a);
      step(tag, 1, 0, a, 8'h00, 0, 0, 0);
   endtask
   task automatic wr(string tag, int a, logic [7:0] d);
      step(tag, 1, 1, a, d, 0, 0, 0);
   endtask
   task automatic hot_add(string tag, int id);
      step(tag, 0, 0, 0, 8'h00, 1, id, 0);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 0; acc_en = 0; add_valid = 0; gpe_clr = '0;
      m_reset();
      repeat (2) @(negedge clk);
      rst_n = 1;
   endtask

   initial begin
      m_reset();
      repeat (3) @(negedge clk);
      rst_n = 1;
      idle("R1");
      rd("R1", 0); rd("R3", 1); rd("R2", 2); rd("R2", 31); idle("R2");
      hot_add("R4", 5); rd("R6", 0); rd("R4", 0);
      hot_add("R4", 19); rd("R4", 2); idle("R4");
      step("R7", 0, 0, 0, 8'h00, 0, 0, 1); idle("R7");
      hot_add("R4", 20); idle("R4"); rd("R4", 2); idle("R4");
      wr("R5", 1, 8'hFF); wr("R5", 2, 8'hFF); wr("R9", 4, 8'h00);
      wr("R9", 5, 8'h00); wr("R9", 0, 8'h55); wr("R9", 3, 8'h80);
      rd("R5", 0); rd("R5", 1); rd("R5", 2); rd("R9", 4); idle("R5");
      hot_add("R6", 9); idle("R6");
      @(negedge clk); gpe_en = 8'h04;
      idle("R8"); idle("R8");
      @(negedge clk); gpe_en = 8'hFB;
      idle("R8");
      @(negedge clk); gpe_en = 8'h04;
      step("R7", 0, 0, 0, 8'h00, 1, 7, 1); idle("R7");
      step("R7", 0, 0, 0, 8'h00, 0, 0, 1); idle("R8");
      rd("R4", 0); rd("R4", 1); idle("R4");
      hot_add("R5", 9); rd("R5", 1); idle("R5");
      wr("R9", 3, 8'h00); idle("R9"); idle("R10");
      rd("R10", 0); rd("R10", 1); idle("R10");
      hot_add("R10", 12); idle("R10");
      wr("R10", 0, 8'h33); idle("R10"); rd("R10", 2); idle("R10");
      do_reset();
      idle("R1"); rd("R1", 0); rd("R1", 1); rd("R1", 2); idle("R1");
      wr("R9", 0, 8'h00); idle("R9"); rd("R10", 0); idle("R10");
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      int cyc = 0;
      while (!done) begin
         @(posedge clk);
         cyc++;
         if (cyc > 20000 && !done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual=%0d cycles expected=done", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
         end
      end
   end
endmodule